// File: doc/BRIEF.md
# Host Interface Interrupt Register Block

This block is a small memory-mapped register file that stands in for a parallel host-interface controller. Its only job is to give a USB host driver the fast interrupt it expects. A simple 32-bit register bus reaches it through a 4 KB window. The bus carries a word address, a write strobe, a read strobe, write data and read data. Behind the window are two data-descriptor words, a control word, an interrupt-status word and a software-interrupt word.

The interrupt output is a held level, not a function of status and enable. Certain register writes raise it or lower it as a side effect of particular data bits, and the level then stays where it is until the next such write. Reads never change state. The control word reads back with a hardwired ready flag at bit 17. All accesses are full 32-bit words with little-endian data. Offsets that are not word aligned, or that fall outside the listed set, are treated as unmapped.

Top module: `hpi_irq_regs`

## Requirements
- R1: While `rst_n` is low at a rising edge, every register clears to zero and `irq` goes to 0. After reset, every mapped offset reads 0, except control, which reads 0x0002_0000.
- R2: A write to offset 0x028 (descriptor A) stores the data, which then reads back unchanged, and leaves `irq` as it was.
- R3: A write to offset 0x02C (descriptor B) stores the data. When data bit 29 is 1, `irq` is 1 from the next cycle on; otherwise `irq` is unchanged.
- R4: A write to offset 0x04C (control) stores the data. When data bit 16 is 1, `irq` is 0 from the next cycle on; otherwise `irq` is unchanged.
- R5: A read of control returns the stored value with bit 17 forced to 1.
- R6: A write to offset 0x050 (interrupt status) stores the data. When data bit 16 or bit 29 is 1, `irq` is 0 from the next cycle on; otherwise `irq` is unchanged.
- R7: A write to offset 0x1F0 ORs the data into the software-interrupt word and sets `irq` to 1 from the next cycle on, even when the data is zero.
- R8: A write to offset 0x1F4 clears the software-interrupt bits that are 1 in the data and sets `irq` to 0 from the next cycle on, even when set bits remain. A read of 0x1F0 or 0x1F4 returns the software-interrupt word.
- R9: A read of any unmapped offset, including misaligned ones, returns 0. A write to an unmapped offset changes no register and leaves `irq` unchanged.
- R10: `irq` holds its value in every cycle that has no write, and reads never change it.
- R11: Read data is combinational in the cycle `rd_en` is high. `rdata` is 0 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte offset within the 4 KB window |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Held interrupt level |

## Verification
The properties assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that the address is stable whenever a strobe is high. The bench drives every access from a task that raises exactly one strobe for a single cycle, with address and data set away from the clock edge, and drops the strobe before the next access. That keeps the stimulus inside these assumptions. Misaligned and out-of-set offsets are driven on purpose, since they are defined as unmapped.

// File: rtl/hpi_irq_regs.sv
module hpi_irq_regs #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFF_DESC_A = ADDR_W'(12'h028);
  localparam logic [ADDR_W-1:0] OFF_DESC_B = ADDR_W'(12'h02C);
  localparam logic [ADDR_W-1:0] OFF_CTRL   = ADDR_W'(12'h04C);
  localparam logic [ADDR_W-1:0] OFF_STAT   = ADDR_W'(12'h050);
  localparam logic [ADDR_W-1:0] OFF_SW_SET = ADDR_W'(12'h1F0);
  localparam logic [ADDR_W-1:0] OFF_SW_CLR = ADDR_W'(12'h1F4);
  localparam int BIT_RAISE_B = 29;
  localparam int BIT_CTRL_LO = 16;
  localparam int BIT_READY   = 17;

  logic [DATA_W-1:0] desc_a_q, desc_b_q, ctrl_q, stat_q, sw_q;

  wire hit_a   = addr == OFF_DESC_A;
  wire hit_b   = addr == OFF_DESC_B;
  wire hit_ctl = addr == OFF_CTRL;
  wire hit_st  = addr == OFF_STAT;
  wire hit_set = addr == OFF_SW_SET;
  wire hit_clr = addr == OFF_SW_CLR;

  wire raise = wr_en & ((hit_b & wdata[BIT_RAISE_B]) | hit_set);
  wire lower = wr_en & ((hit_ctl & wdata[BIT_CTRL_LO])
                      | (hit_st & (wdata[BIT_CTRL_LO] | wdata[BIT_RAISE_B]))
                      | hit_clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc_a_q <= '0;
      desc_b_q <= '0;
      ctrl_q   <= '0;
      stat_q   <= '0;
      sw_q     <= '0;
      irq      <= 1'b0;
    end else begin
      if (wr_en) begin
        if (hit_a)   desc_a_q <= wdata;
        if (hit_b)   desc_b_q <= wdata;
        if (hit_ctl) ctrl_q   <= wdata;
        if (hit_st)  stat_q   <= wdata;
        if (hit_set) sw_q     <= sw_q | wdata;
        if (hit_clr) sw_q     <= sw_q & ~wdata;
      end
      if (raise)      irq <= 1'b1;
      else if (lower) irq <= 1'b0;
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      hit_a:             rd_mux = desc_a_q;
      hit_b:             rd_mux = desc_b_q;
      hit_ctl:           rd_mux = ctrl_q | (DATA_W'(1) << BIT_READY);
      hit_st:            rd_mux = stat_q;
      hit_set, hit_clr:  rd_mux = sw_q;
      default:           rd_mux = '0;
    endcase
  end

  assign rdata = rd_en ? rd_mux : '0;
endmodule

// File: rtl/hpi_irq_regs_chk.sv
module hpi_irq_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        irq
);
  wire mapped = addr == 12'h028 || addr == 12'h02C || addr == 12'h04C ||
                addr == 12'h050 || addr == 12'h1F0 || addr == 12'h1F4;

  AST_DESC_B_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 12'h02C && wdata[29] |=> irq); // R3
  AST_CTRL_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 12'h04C && wdata[16] |=> !irq); // R4
  AST_CTRL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 12'h04C |-> rdata[17]); // R5
  AST_STAT_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 12'h050 && (wdata[16] || wdata[29]) |=> !irq); // R6
  AST_SW_SET_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 12'h1F0 |=> irq); // R7
  AST_SW_CLR_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 12'h1F4 |=> !irq); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !mapped |-> rdata == 32'h0); // R9
  AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !mapped |=> $stable(irq)); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(irq)); // R10
  AST_RD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 32'h0); // R11
endmodule

bind hpi_irq_regs hpi_irq_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .irq(irq)
);

// File: tb/hpi_irq_regs_tb.sv
`timescale 1ns/1ps
module hpi_irq_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hpi_irq_regs u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic check_irq(string req, logic exp);
    check32(req, "irq", {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    check32(req, $sformatf("read 0x%03h", a), rdata, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    check_irq("R1", 1'b0);
    rd("R1", 12'h028, 32'h0);
    rd("R1", 12'h02C, 32'h0);
    rd("R1", 12'h04C, 32'h0002_0000);
    rd("R1", 12'h050, 32'h0);
    rd("R1", 12'h1F0, 32'h0);
    rd("R1", 12'h1F4, 32'h0);
  endtask

  task automatic t_desc_a();
    wr(12'h028, 32'hA5A5_0001);
    check_irq("R2", 1'b0);
    rd("R2", 12'h028, 32'hA5A5_0001);
    wr(12'h1F0, 32'h0);
    wr(12'h028, 32'hFFFF_FFFF);
    check_irq("R2", 1'b1);
    rd("R2", 12'h028, 32'hFFFF_FFFF);
    wr(12'h1F4, 32'h0);
    check_irq("R8", 1'b0);
  endtask

  task automatic t_desc_b();
    wr(12'h02C, 32'h0000_1234);
    check_irq("R3", 1'b0);
    rd("R3", 12'h02C, 32'h0000_1234);
    wr(12'h02C, 32'h2000_0000);
    check_irq("R3", 1'b1);
    rd("R3", 12'h02C, 32'h2000_0000);
    check_irq("R10", 1'b1);
  endtask

  task automatic t_ctrl();
    wr(12'h04C, 32'h0000_00FF);
    check_irq("R4", 1'b1);
    rd("R5", 12'h04C, 32'h0002_00FF);
    wr(12'h04C, 32'h0001_0000);
    check_irq("R4", 1'b0);
    rd("R5", 12'h04C, 32'h0003_0000);
    wr(12'h04C, 32'h0002_0000);
    rd("R5", 12'h04C, 32'h0002_0000);
  endtask

  task automatic t_status();
    wr(12'h02C, 32'h2000_0000);
    wr(12'h050, 32'h0000_0005);
    check_irq("R6", 1'b1);
    wr(12'h050, 32'h0001_0000);
    check_irq("R6", 1'b0);
    wr(12'h02C, 32'h2000_0000);
    check_irq("R3", 1'b1);
    wr(12'h050, 32'h2000_0000);
    check_irq("R6", 1'b0);
    rd("R6", 12'h050, 32'h2000_0000);
  endtask

  task automatic t_swirq();
    wr(12'h1F0, 32'h0000_0003);
    check_irq("R7", 1'b1);
    rd("R8", 12'h1F0, 32'h0000_0003);
    rd("R8", 12'h1F4, 32'h0000_0003);
    wr(12'h1F0, 32'h0000_0010);
    rd("R7", 12'h1F0, 32'h0000_0013);
    wr(12'h1F4, 32'h0000_0001);
    check_irq("R8", 1'b0);
    rd("R8", 12'h1F4, 32'h0000_0012);
    wr(12'h1F4, 32'h0);
    check_irq("R8", 1'b0);
    wr(12'h1F0, 32'h0);
    check_irq("R7", 1'b1);
    rd("R7", 12'h1F0, 32'h0000_0012);
  endtask

  task automatic t_unmapped();
    rd("R9", 12'h000, 32'h0);
    rd("R9", 12'h02A, 32'h0);
    rd("R9", 12'hFFC, 32'h0);
    wr(12'h030, 32'hFFFF_FFFF);
    check_irq("R9", 1'b1);
    wr(12'h1F8, 32'hFFFF_FFFF);
    wr(12'h04E, 32'h0001_0000);
    check_irq("R9", 1'b1);
    rd("R9", 12'h028, 32'hFFFF_FFFF);
    rd("R9", 12'h02C, 32'h2000_0000);
    rd("R9", 12'h04C, 32'h0002_0000);
    rd("R9", 12'h1F0, 32'h0000_0012);
  endtask

  task automatic t_rd_gate();
    @(negedge clk);
    addr = 12'h028; rd_en = 1'b0;
    #1;
    check32("R11", "rdata idle", rdata, 32'h0);
    repeat (5) @(negedge clk);
    check_irq("R10", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_desc_a();
    t_desc_b();
    t_ctrl();
    t_status();
    t_swirq();
    t_unmapped();
    t_rd_gate();
    do_reset();
    t_reset();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule